// File: doc/BRIEF.md
# Instruction cache valid-bit and control unit

This block manages a small direct-mapped instruction cache of long-word entries. It does not hold the instruction data. It holds the per-entry valid bits and tags, a control register and an address register, and it tells a fetch unit whether the cache is active and whether a lookup hits. A privileged register port writes either register with a one-cycle strobe and reads the selected register back combinationally.

The control register holds two persistent bits and two command bits. The persistent bits are enable, at bit 0, and freeze, at bit 1. The command bits act on the valid array at the moment of the write and always read back as zero. Bit 3 invalidates every entry. Bit 2 invalidates the single entry chosen by the index field of the address register, which is address bits [IDX_W+1:2]. An external disable input turns the cache off whatever the enable bit holds.

While the cache is enabled and not frozen, a fill request sets the valid bit and the tag of the entry that the fill address selects. While it is frozen, existing entries still hit but misses allocate nothing.

Top module: `icache_ctl`

## Requirements
- R1: After reset the control register reads 0, the address register reads 0, cache_on is low and no lookup hits.
- R2: With reg_sel=0 the read data is {30 zeros, freeze, enable}, with enable at bit 0 and freeze at bit 1. Bits 31..2 always read as zero, including the command bits 2 and 3, and writes to bits 31..4 have no effect.
- R3: With reg_sel=1 all 32 bits of the address register read back as last written.
- R4: lk_hit is high only when enable is 1, cache_dis is low, the entry indexed by lk_addr[IDX_W+1:2] is valid, and its stored tag equals lk_addr[ADDR_W-1:IDX_W+2].
- R5: A fill request writes the valid bit and the tag of the entry at fill_addr only when enable=1, cache_dis=0 and freeze=0. When freeze=1, a miss allocates nothing and existing entries still hit.
- R6: A control write with bit 3 set invalidates every entry in the array.
- R7: A control write with bit 2 set invalidates only the entry indexed by address-register bits [IDX_W+1:2], whatever the written or held values of enable and freeze. The other address-register bits are ignored.
- R8: While cache_dis is high, cache_on is low, no lookup hits and fills are discarded.
- R9: If an invalidation and a fill hit the same entry in the same cycle, the entry ends invalid.
- R10: cache_on is high exactly when enable is 1 and cache_dis is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | One-cycle register write strobe |
| reg_sel | input | 1 | 0 selects the control register, 1 selects the address register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data of the selected register |
| cache_dis | input | 1 | External cache disable |
| cache_on | output | 1 | Cache active (enable bit set and not disabled) |
| lk_addr | input | ADDR_W | Lookup fetch address |
| lk_hit | output | 1 | Lookup hit |
| fill_req | input | 1 | Fill request for fill_addr |
| fill_addr | input | ADDR_W | Address of the long word being filled |

## Verification
The bench builds the block with its defaults, 64 entries and 32-bit addresses, so the index sits in bits 7:2 and the tag in bits 31:8. These values let the bench pick addresses that share an index but differ in tag, and neighbouring indices that a single-entry clear must leave alone. Because the address register is written with ones above the index field, the bench also shows that those bits have no effect on which entry is cleared. A fill and an invalidation are driven in the same cycle to check which one prevails.

// File: rtl/icache_ctl.sv
module icache_ctl #(
  parameter int IDX_W  = 6,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              cache_dis,
  output logic              cache_on,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  input  logic              fill_req,
  input  logic [ADDR_W-1:0] fill_addr
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_LSB = IDX_W + 2;
  localparam int TAG_W   = ADDR_W - TAG_LSB;

  logic               en_q, frz_q;
  logic [31:0]        aar_q;
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];

  wire ctrl_wr = reg_wr & ~reg_sel;
  wire aar_wr  = reg_wr & reg_sel;
  wire clr_all = ctrl_wr & reg_wdata[3];
  wire clr_one = ctrl_wr & reg_wdata[2];

  wire [IDX_W-1:0] clr_idx  = aar_q[IDX_W+1:2];
  wire [IDX_W-1:0] fill_idx = fill_addr[IDX_W+1:2];
  wire [IDX_W-1:0] lk_idx   = lk_addr[IDX_W+1:2];
  wire [TAG_W-1:0] fill_tag = fill_addr[ADDR_W-1:TAG_LSB];
  wire [TAG_W-1:0] lk_tag   = lk_addr[ADDR_W-1:TAG_LSB];

  wire unused_ok = ^{lk_addr[1:0], fill_addr[1:0]};

  assign cache_on  = en_q & ~cache_dis;
  wire   fill_ok   = fill_req & cache_on & ~frz_q;
  assign lk_hit    = cache_on & valid_q[lk_idx] & (tag_q[lk_idx] == lk_tag);
  assign reg_rdata = reg_sel ? aar_q : {30'b0, frz_q, en_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      frz_q   <= 1'b0;
      aar_q   <= '0;
      valid_q <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q  <= reg_wdata[0];
        frz_q <= reg_wdata[1];
      end
      if (aar_wr) aar_q <= reg_wdata;
      if (fill_ok) valid_q[fill_idx] <= 1'b1;
      if (clr_one) valid_q[clr_idx] <= 1'b0;
      if (clr_all) valid_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_ok) tag_q[fill_idx] <= fill_tag;
  end
endmodule

module icache_ctl_chk #(
  parameter int IDX_W  = 6,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_sel,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              cache_dis,
  input logic              cache_on,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              lk_hit,
  input logic [31:0]       aar_q
);
  assert_ctrl_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> reg_rdata[31:2] == '0);

  assert_hit_needs_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> cache_on);

  assert_dis_blocks_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cache_dis |-> (!lk_hit && !cache_on));

  assert_clear_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_wr && !reg_sel && reg_wdata[3]) |-> !lk_hit);

  assert_clear_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_wr && !reg_sel && reg_wdata[2]) &&
     lk_addr[IDX_W+1:2] == $past(aar_q[IDX_W+1:2])) |-> !lk_hit);
endmodule

bind icache_ctl icache_ctl_chk #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cache_dis(cache_dis),
  .cache_on(cache_on), .lk_addr(lk_addr), .lk_hit(lk_hit), .aar_q(aar_q)
);

// File: tb/icache_ctl_tb.sv
module icache_ctl_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0, reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        cache_dis = 0, cache_on, lk_hit, fill_req = 0;
  logic [31:0] lk_addr = 0, fill_addr = 0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  icache_ctl u_dut (.*);

  localparam logic [31:0] A = 32'h1000_0040;
  localparam logic [31:0] A2 = 32'h2000_0040;
  localparam logic [31:0] B = 32'h3000_0080;
  localparam logic [31:0] C = 32'h4000_0044;

  typedef struct packed { logic sel; logic [31:0] wd; logic [31:0] exp; } vec_t;
  localparam vec_t VECS [8] = '{
    '{1'b0, 32'hFFFF_FFF3, 32'h0000_0003},
    '{1'b0, 32'h0000_000C, 32'h0000_0000},
    '{1'b0, 32'h0000_0001, 32'h0000_0001},
    '{1'b0, 32'h0000_0002, 32'h0000_0002},
    '{1'b1, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    '{1'b1, 32'h0000_0000, 32'h0000_0000},
    '{1'b0, 32'hA5A5_A5F0, 32'h0000_0000},
    '{1'b1, 32'h5A5A_5A5A, 32'h5A5A_5A5A}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input string req, input logic sel, input logic [31:0] exp);
    reg_sel = sel; #1; chk(req, reg_rdata, exp);
  endtask

  task automatic fill(input logic [31:0] a);
    @(negedge clk); fill_req = 1; fill_addr = a;
    @(negedge clk); fill_req = 0;
  endtask

  task automatic look(input string req, input logic [31:0] a, input logic exp);
    lk_addr = a; #1; chk(req, {31'b0, lk_hit}, {31'b0, exp});
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd("R1 ctrl", 0, 0);
    rd("R1 addr", 1, 0);
    chk("R1 cache_on", {31'b0, cache_on}, 0);
    look("R1 no hit", A, 0);

    // R2 R3 register table
    for (int i = 0; i < 8; i++) begin
      wr(VECS[i].sel, VECS[i].wd);
      rd(VECS[i].sel ? "R3 readback" : "R2 readback", VECS[i].sel, VECS[i].exp);
    end
    wr(1, 0);

    // R10 R5 R4
    wr(0, 32'h1);
    chk("R10 on", {31'b0, cache_on}, 1);
    fill(A);
    look("R5 fill hit", A, 1);
    look("R4 tag mismatch", A2, 0);
    look("R4 other index", C, 0);

    // R8 disable
    cache_dis = 1; #1;
    chk("R8 cache_on", {31'b0, cache_on}, 0);
    look("R8 no hit", A, 0);
    fill(B);
    cache_dis = 0; #1;
    look("R8 fill dropped", B, 0);
    look("R8 entry kept", A, 1);

    // R4 enable off
    wr(0, 32'h0);
    look("R4 disabled miss", A, 0);
    chk("R10 off", {31'b0, cache_on}, 0);
    fill(B);
    wr(0, 32'h1);
    look("R5 fill while E=0 dropped", B, 0);
    look("R4 re-enabled hit", A, 1);

    // R5 freeze
    wr(0, 32'h3);
    fill(B);
    look("R5 frozen no alloc", B, 0);
    look("R5 frozen still hits", A, 1);

    // R7 single entry clear, E=0 F=1 in the same write
    wr(0, 32'h1);
    fill(B);
    fill(C);
    wr(1, 32'hFFFF_FF40);
    wr(0, 32'h6);
    wr(0, 32'h1);
    look("R7 target cleared", A, 0);
    look("R7 other kept B", B, 1);
    look("R7 neighbour kept C", C, 1);

    // R6 clear all
    wr(0, 32'h9);
    look("R6 B cleared", B, 0);
    look("R6 C cleared", C, 0);
    chk("R6 enable kept", {31'b0, cache_on}, 1);

    // R9 invalidate beats fill
    @(negedge clk);
    reg_wr = 1; reg_sel = 0; reg_wdata = 32'h5; fill_req = 1; fill_addr = A;
    @(negedge clk); reg_wr = 0; fill_req = 0;
    look("R9 clear one vs fill", A, 0);
    @(negedge clk);
    reg_wr = 1; reg_sel = 0; reg_wdata = 32'h9; fill_req = 1; fill_addr = C;
    @(negedge clk); reg_wr = 0; fill_req = 0;
    look("R9 clear all vs fill", C, 0);
    fill(C);
    look("R5 plain fill after", C, 1);

    // R1 reset again clears everything
    rst_n = 0; @(negedge clk); rst_n = 1;
    rd("R1 ctrl after reset", 0, 0);
    wr(0, 32'h1);
    look("R1 valid cleared", C, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule